// File: doc/BRIEF.md
# Snooze Power-Down Sequencer

This block sequences a synchronous memory into and out of a low-current snooze state. An active-high request arrives with no timing relation to the clock. It passes through a flop chain, and a small state machine then counts out a fixed entry delay before it raises three controls. The controls gate off the command inputs, force the data drivers to high impedance and flag the low-power state. The stored contents are untouched throughout.

When the request is released, the low-power indication drops on the first clock edge that sees the synchronised request low. The input gate and the high-impedance force stay up through a fixed recovery window. During that window the block watches the command bus and flags any command other than a deselect or a read. It also raises a one-cycle warning when the request lands while a read or write is still in flight, because that operation may not complete.

Top module: `snz_sequencer`

## Requirements
- R1: After reset, `input_gate`, `hiz_force`, `low_power`, `recovery_err` and `pending_warn` are all low.
- R2: The request passes through SYNC_STAGES flops (default 2), and the state machine reacts on the next edge. With defaults, a request that rises before rising edge 1 makes `input_gate`, `hiz_force` and `low_power` high after edge ENTRY_CYCLES+3 (edge 5). They are not high before that edge.
- R3: In the snooze state all three controls are high. During the entry countdown all three are low.
- R4: If the synchronised request falls before the entry countdown completes, the block returns to normal operation and none of the three controls ever asserts.
- R5: `low_power` falls after the first edge at which the state machine sees the synchronised request low. With defaults, a release before edge 1 drops it after edge 3.
- R6: `input_gate` and `hiz_force` stay high for EXIT_CYCLES further edges after `low_power` falls. With defaults they fall after edge 5 counted from the release.
- R7: In the recovery window, a command with `cmd_valid` high and `cmd_op` equal to write (2'b10) or burst-continue (2'b11) makes `recovery_err` high for exactly the cycle after the sampling edge. Deselect (2'b00) and read (2'b01) do not.
- R8: Commands presented in normal operation, during entry or in snooze never raise `recovery_err`.
- R9: `pending_warn` is high for one cycle after the edge at which the state machine first sees the synchronised request, provided `op_pending` is high at that edge. It stays low in every other case.
- R10: A request that returns during the recovery window does not cut the window short. Recovery completes, and a fresh entry countdown of ENTRY_CYCLES edges starts on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snooze_req | input | 1 | Asynchronous active-high snooze request |
| op_pending | input | 1 | High while a read or write has not yet completed |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 2 | Command code: 00 deselect, 01 read, 10 write, 11 burst-continue |
| input_gate | output | 1 | High while synchronous inputs must be ignored |
| hiz_force | output | 1 | High while data drivers must be high impedance |
| low_power | output | 1 | High in the low-current state |
| recovery_err | output | 1 | One-cycle flag for an illegal command during recovery |
| pending_warn | output | 1 | One-cycle flag for a request that lands on an in-flight operation |

## Verification
The bench uses the defaults: two synchroniser stages and two cycles each for entry and recovery. With these values every edge of both windows can be checked one by one. All four command codes are swept into each of the two recovery slots and into normal and snooze operation. The short windows also bring several corner cases within a few cycles: an entry aborted mid-countdown, a request that returns mid-recovery, and the pending-operation warning with `op_pending` both high and low.

// File: rtl/snz_pkg.sv
package snz_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_ENTER   = 2'd1,
    ST_SNOOZE  = 2'd2,
    ST_RECOVER = 2'd3
  } snz_state_e;

  typedef enum logic [1:0] {
    OP_DESEL = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_BURST = 2'd3
  } snz_op_e;
endpackage

// File: rtl/snz_sync.sv
module snz_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/snz_fsm.sv
module snz_fsm
  import snz_pkg::*;
#(
  parameter int ENTRY_CYCLES = 2,
  parameter int EXIT_CYCLES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_s,
  output snz_state_e state,
  output logic       entry_start
);
  localparam int MAXC  = (ENTRY_CYCLES > EXIT_CYCLES) ? ENTRY_CYCLES : EXIT_CYCLES;
  localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CNT_W-1:0] ENTRY_LOAD = CNT_W'(ENTRY_CYCLES - 1);
  localparam logic [CNT_W-1:0] EXIT_LOAD  = CNT_W'(EXIT_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign entry_start = (state == ST_ACTIVE) && req_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_ACTIVE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_ACTIVE: if (req_s) begin
          state <= ST_ENTER;
          cnt   <= ENTRY_LOAD;
        end
        ST_ENTER: begin
          if (!req_s)         state <= ST_ACTIVE;
          else if (cnt == '0) state <= ST_SNOOZE;
          else                cnt   <= cnt - 1'b1;
        end
        ST_SNOOZE: if (!req_s) begin
          state <= ST_RECOVER;
          cnt   <= EXIT_LOAD;
        end
        ST_RECOVER: begin
          if (cnt == '0) state <= ST_ACTIVE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= ST_ACTIVE;
      endcase
    end
  end

  assert_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ENTER && !req_s) |=> state == ST_ACTIVE);

  assert_exit_now_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SNOOZE && !req_s) |=> state == ST_RECOVER);

  assert_recover_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_RECOVER |=> (state == ST_RECOVER || state == ST_ACTIVE));

  assert_snooze_via_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == ST_SNOOZE) |-> $past(state == ST_ENTER && req_s));
endmodule

// File: rtl/snz_cmd_check.sv
module snz_cmd_check
  import snz_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_recover,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       entry_start,
  input  logic       op_pending,
  output logic       recovery_err,
  output logic       pending_warn
);
  logic legal_op;
  assign legal_op = (cmd_op == OP_DESEL) || (cmd_op == OP_READ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      recovery_err <= 1'b0;
      pending_warn <= 1'b0;
    end else begin
      recovery_err <= in_recover && cmd_valid && !legal_op;
      pending_warn <= entry_start && op_pending;
    end
  end

  assert_err_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    recovery_err |-> $past(in_recover));

  assert_err_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    recovery_err |-> $past(cmd_valid && cmd_op[1]));

  assert_warn_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pending_warn |-> $past(op_pending && entry_start));
endmodule

// File: rtl/snz_sequencer.sv
module snz_sequencer
  import snz_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int ENTRY_CYCLES = 2,
  parameter int EXIT_CYCLES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       snooze_req,
  input  logic       op_pending,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  output logic       input_gate,
  output logic       hiz_force,
  output logic       low_power,
  output logic       recovery_err,
  output logic       pending_warn
);
  logic       req_s;
  logic       entry_start;
  snz_state_e state;

  snz_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(snooze_req), .sync_out(req_s)
  );

  snz_fsm #(.ENTRY_CYCLES(ENTRY_CYCLES), .EXIT_CYCLES(EXIT_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_s(req_s), .state(state), .entry_start(entry_start)
  );

  snz_cmd_check u_chk (
    .clk(clk), .rst_n(rst_n), .in_recover(state == ST_RECOVER),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .entry_start(entry_start),
    .op_pending(op_pending), .recovery_err(recovery_err), .pending_warn(pending_warn)
  );

  assign low_power  = (state == ST_SNOOZE);
  assign input_gate = (state == ST_SNOOZE) || (state == ST_RECOVER);
  assign hiz_force  = input_gate;

  assert_lp_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    low_power |-> (input_gate && hiz_force));

  assert_lp_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(low_power) |-> (input_gate && !$past(req_s)));

  assert_gate_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(input_gate) |-> $past(!low_power));
endmodule

// File: tb/sim_snz_sequencer.sv
module sim_snz_sequencer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic snooze_req = 1'b0;
  logic op_pending = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic input_gate, hiz_force, low_power, recovery_err, pending_warn;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  snz_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .snooze_req(snooze_req), .op_pending(op_pending),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .input_gate(input_gate),
    .hiz_force(hiz_force), .low_power(low_power), .recovery_err(recovery_err),
    .pending_warn(pending_warn)
  );

  task automatic chk(string rid, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", rid, what, act, exp, $time);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic enter_snooze();
    snooze_req = 1'b1;
    tick(6);
  endtask

  initial begin
    tick(3);
    chk("R1", "low_power", low_power, 1'b0);
    chk("R1", "input_gate", input_gate, 1'b0);
    chk("R1", "hiz_force", hiz_force, 1'b0);
    chk("R1", "recovery_err", recovery_err, 1'b0);
    chk("R1", "pending_warn", pending_warn, 1'b0);
    rst_n = 1'b1;
    tick(3);
    chk("R1", "low_power idle", low_power, 1'b0);

    // Entry timing, edge by edge (R2, R3)
    snooze_req = 1'b1;
    for (int k = 1; k <= 7; k++) begin
      tick();
      chk("R2", "low_power entry", low_power, k >= 5);
      chk("R3", "input_gate entry", input_gate, k >= 5);
      chk("R3", "hiz_force entry", hiz_force, k >= 5);
      chk("R9", "no warn", pending_warn, 1'b0);
    end
    // Commands in snooze: no error (R8)
    for (int op = 0; op < 4; op++) begin
      cmd_valid = 1'b1; cmd_op = 2'(op);
      tick();
      chk("R8", "err in snooze", recovery_err, 1'b0);
    end
    cmd_valid = 1'b0;

    // Exit timing (R5, R6)
    snooze_req = 1'b0;
    for (int k = 1; k <= 7; k++) begin
      tick();
      chk("R5", "low_power exit", low_power, k < 3);
      chk("R6", "input_gate exit", input_gate, k < 5);
      chk("R6", "hiz_force exit", hiz_force, k < 5);
    end

    // Commands in normal operation (R8)
    for (int op = 0; op < 4; op++) begin
      cmd_valid = 1'b1; cmd_op = 2'(op);
      tick();
      chk("R8", "err in active", recovery_err, 1'b0);
    end
    cmd_valid = 1'b0;

    // Recovery command sweep (R7)
    for (int op = 0; op < 4; op++) begin
      for (int slot = 0; slot < 2; slot++) begin
        enter_snooze();
        snooze_req = 1'b0;
        tick(3 + slot);
        cmd_valid = 1'b1; cmd_op = 2'(op);
        tick();
        cmd_valid = 1'b0;
        chk("R7", "err in recovery", recovery_err, op >= 2);
        tick();
        chk("R7", "err one cycle", recovery_err, 1'b0);
        tick(4);
      end
    end

    // First edge after recovery is normal operation (R8)
    enter_snooze();
    snooze_req = 1'b0;
    tick(5);
    cmd_valid = 1'b1; cmd_op = 2'b10;
    tick();
    cmd_valid = 1'b0;
    chk("R8", "err after recovery", recovery_err, 1'b0);
    tick(3);

    // Commands during entry countdown (R8)
    snooze_req = 1'b1;
    tick(3);
    cmd_valid = 1'b1; cmd_op = 2'b10;
    tick();
    chk("R8", "err during entry", recovery_err, 1'b0);
    cmd_valid = 1'b0;
    tick(3);
    snooze_req = 1'b0;
    tick(8);

    // Aborted entry (R4)
    snooze_req = 1'b1;
    tick(2);
    snooze_req = 1'b0;
    for (int k = 3; k <= 10; k++) begin
      tick();
      chk("R4", "low_power abort", low_power, 1'b0);
      chk("R4", "input_gate abort", input_gate, 1'b0);
    end

    // Pending warning (R9)
    op_pending = 1'b1;
    tick(3);
    chk("R9", "warn idle pending", pending_warn, 1'b0);
    snooze_req = 1'b1;
    tick(2);
    chk("R9", "warn before", pending_warn, 1'b0);
    tick();
    chk("R9", "warn pulse", pending_warn, 1'b1);
    tick();
    chk("R9", "warn single", pending_warn, 1'b0);
    op_pending = 1'b0;
    tick(3);
    snooze_req = 1'b0;
    tick(8);

    // Request returns during recovery (R10)
    enter_snooze();
    snooze_req = 1'b0;
    tick(3);
    snooze_req = 1'b1;
    tick(2);
    chk("R10", "input_gate after recovery", input_gate, 1'b0);
    tick();
    chk("R10", "low_power countdown", low_power, 1'b0);
    tick();
    chk("R10", "low_power countdown", low_power, 1'b0);
    tick();
    chk("R10", "low_power reentry", low_power, 1'b1);
    chk("R10", "input_gate reentry", input_gate, 1'b1);
    snooze_req = 1'b0;
    tick(8);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule